// File: doc/BRIEF.md
# Dual-Port Double-Data-Rate Burst-of-Two SRAM Core

This block is a synthesizable behavioural model of a static memory with one read data port and one write data port. Both ports work at the same time and share a single address bus, which is used twice per input clock cycle. Every access moves a pair of 18-bit words. The first word of a pair is held in one storage array and the second word in a second array. Each array has a depth of 2^ADDR_W entries.

The model uses one clock, `clk`, whose rising edges alternate between the two phases of the input clock pair. The first rising edge after reset is released is a primary-phase (K) edge. The next edge is a complementary-phase (K#) edge, and the pattern repeats. The same edges launch the read data, which models the single-clock-domain case where the output clocks follow the input clocks.

On a K edge the block samples the read address, both active-low port selects, the first write word and its lane enables. On a K# edge it samples the write address, the second write word and its lane enables. A read returns its two words on the third and fourth edges after its command. Any write whose command was sampled on the same K edge as the read, or on an earlier one, is already visible to that read. A write that has not yet reached the array is passed forward to the read.

Top module: `qdr_b2_sram`

## Requirements
- R1: While `rst_n` is low, and on the first sample after any reset, `rd_valid` is 0 and `rd_data` is 0. Reset also empties every read that was in flight.
- R2: A read command has `rd_sel_n` low on a K edge. Its first word appears after the third edge following that K edge, which is a K# edge, and stays one edge. Its second word appears after the fourth edge. `rd_valid` is 1 for both edges.
- R3: If `rd_sel_n` is high on a K edge, that slot produces no burst. For those two output edges `rd_valid` is 0 and `rd_data` is 0.
- R4: A write command has `wr_sel_n` low on a K edge. It stores the data on `wdata` at that K edge as word 0 and the data at the following K# edge as word 1. Both words go to the address presented at that K# edge.
- R5: `wr_lane_n` bit 0 low enables bits 8:0 of the word being sampled, and bit 1 low enables bits 17:9. The two words are masked independently. A disabled lane keeps its previous contents.
- R6: If `wr_sel_n` is high on a K edge, the array is not changed, whatever is on `wdata`, `wr_lane_n` and `addr`.
- R7: A read whose command shares a K edge with a write to the same address returns the newly written lanes. In the disabled lanes it returns the old contents.
- R8: If a read command is given on every K edge, the bursts follow each other with no gap, and `rd_valid` stays high for the whole run.
- R9: A read and a write to different addresses can be given on the same K edge without affecting each other. The read uses the address from the K edge, and the write uses the address from the K# edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock. Its rising edges alternate K then K#, starting with K after reset. |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Shared address: read address on K edges, write address on K# edges |
| rd_sel_n | input | 1 | Read port select, active low, sampled on K edges |
| wr_sel_n | input | 1 | Write port select, active low, sampled on K edges |
| wdata | input | 18 | Write data: word 0 on K edges, word 1 on K# edges |
| wr_lane_n | input | 2 | Lane enables, active low. Bit 0 controls bits 8:0 and bit 1 controls bits 17:9. |
| rd_data | output | 18 | Registered read data. It is 0 when no burst is being output. |
| rd_valid | output | 1 | High on each edge that carries a read word |

## Verification
The assertions assume that `addr` is a known value on every K edge that samples a read command, and on every K# edge that follows a write command. They also assume that the first edge after reset release is a K edge. The bench meets these conditions by releasing reset on a falling edge. It then drives every K cycle through one task, which sets the read address before the K edge and the write address before the K# edge. Every address it reads has been written before, so the expected words are always known values.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
    localparam int LANE_W  = 9;
    localparam int NLANE   = 2;
    localparam int WORD_W  = LANE_W * NLANE;
    localparam int BURST   = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [NLANE-1:0]  lane_t;
endpackage

// File: rtl/qdr_lane_merge.sv
module qdr_lane_merge
    import qdr_pkg::*;
(
    input  word_t old_word,
    input  word_t new_word,
    input  lane_t lane_en,
    output word_t merged
);
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] = lane_en[g] ? new_word[g*LANE_W +: LANE_W]
                                                       : old_word[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/qdr_bank.sv
module qdr_bank
    import qdr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  lane_t             lane_en,
    input  logic [ADDR_W-1:0] waddr,
    input  word_t             wword,
    input  logic [ADDR_W-1:0] raddr,
    output word_t             rword
);
    localparam int DEPTH = 1 << ADDR_W;

    // One storage column per lane so that a masked write touches only its lanes.
    for (genvar g = 0; g < NLANE; g++) begin : g_col
        logic [LANE_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we && lane_en[g]) begin
                mem[waddr] <= wword[g*LANE_W +: LANE_W];
            end
        end
        assign rword[g*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/qdr_b2_sram.sv
module qdr_b2_sram
    import qdr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_sel_n,
    input  logic              wr_sel_n,
    input  logic [17:0]       wdata,
    input  logic [1:0]        wr_lane_n,
    output logic [17:0]       rd_data,
    output logic              rd_valid
);
    typedef struct packed {
        logic                         ph;       // 0: next edge is K, 1: next edge is K#
        logic                         rd_act;   // read command taken on last K edge
        logic [ADDR_W-1:0]            rd_addr;
        logic                         buf_vld;  // burst held for output
        logic [BURST-1:0][WORD_W-1:0] buf_word;
        logic                         w_act;    // write command in flight
        logic [ADDR_W-1:0]            w_addr;
        logic [BURST-1:0][WORD_W-1:0] w_word;
        logic [BURST-1:0][NLANE-1:0]  w_en;
        logic                         dval;
        logic [WORD_W-1:0]            dout;
    } st_t;

    st_t st_d, st_q;

    word_t bank_rd [BURST];
    word_t merged  [BURST];
    word_t fwd     [BURST];
    logic  bank_we;
    logic  fwd_hit;

    // The pending write commits on a K edge; the read of that same edge sees it by forwarding.
    assign bank_we = !st_q.ph && st_q.w_act;
    assign fwd_hit = st_q.w_act && (st_q.w_addr == st_q.rd_addr);

    for (genvar p = 0; p < BURST; p++) begin : g_pos
        qdr_bank #(.ADDR_W(ADDR_W)) u_bank (
            .clk     (clk),
            .we      (bank_we),
            .lane_en (st_q.w_en[p]),
            .waddr   (st_q.w_addr),
            .wword   (st_q.w_word[p]),
            .raddr   (st_q.rd_addr),
            .rword   (bank_rd[p])
        );
        qdr_lane_merge u_merge (
            .old_word (bank_rd[p]),
            .new_word (st_q.w_word[p]),
            .lane_en  (st_q.w_en[p]),
            .merged   (merged[p])
        );
        assign fwd[p] = fwd_hit ? merged[p] : bank_rd[p];
    end

    always_comb begin
        st_d      = st_q;
        st_d.ph   = ~st_q.ph;
        st_d.dval = st_q.buf_vld;
        if (!st_q.ph) begin
            // K edge: read command, write command, first write word; second output word.
            st_d.rd_act      = ~rd_sel_n;
            st_d.rd_addr     = addr;
            st_d.buf_vld     = st_q.rd_act;
            st_d.buf_word[0] = fwd[0];
            st_d.buf_word[1] = fwd[1];
            st_d.w_act       = ~wr_sel_n;
            st_d.w_word[0]   = wdata;
            st_d.w_en[0]     = ~wr_lane_n;
            st_d.dout        = st_q.buf_vld ? st_q.buf_word[1] : '0;
        end else begin
            // K# edge: write address, second write word; first output word.
            st_d.w_addr      = addr;
            st_d.w_word[1]   = wdata;
            st_d.w_en[1]     = ~wr_lane_n;
            st_d.dout        = st_q.buf_vld ? st_q.buf_word[0] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data  = st_q.dout;
    assign rd_valid = st_q.dval;

    // R3: an idle output slot is driven to zero
    assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == '0);

    // R2: a burst begins on a K# edge (next edge is K)
    assert_first_on_kbar_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> !st_q.ph);

    // R2: a burst lasts at least two output edges
    assert_burst_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |=> rd_valid);

    // R9: the read address is known when a read command is sampled
    assert_rd_addr_known_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ph && !rd_sel_n) |-> !$isunknown(addr));

    // R4: the write address is known on the K# edge of a write
    assert_wr_addr_known_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph && st_q.w_act) |-> !$isunknown(addr));
endmodule

// File: tb/qdr_b2_sram_test.sv
module qdr_b2_sram_test;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          rd_sel_n = 1'b1;
    logic          wr_sel_n = 1'b1;
    logic [17:0]   wdata = '0;
    logic [1:0]    wr_lane_n = 2'b11;
    logic [17:0]   rd_data;
    logic          rd_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    qdr_b2_sram #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_sel_n(rd_sel_n),
        .wr_sel_n(wr_sel_n), .wdata(wdata), .wr_lane_n(wr_lane_n),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    logic [17:0] ref0 [1<<AW];
    logic [17:0] ref1 [1<<AW];

    logic        p1_v = 1'b0, p2_v = 1'b0;
    logic [17:0] p1_w0 = '0, p1_w1 = '0, p2_w0 = '0, p2_w1 = '0;
    string       p1_tag = "R3", p2_tag = "R3";

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic [5:0]  ra;
        logic [5:0]  wa;
        logic [17:0] w0;
        logic [17:0] w1;
        logic [1:0]  b0n;
        logic [1:0]  b1n;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b1, 6'd0, 6'd1, 18'h11111, 18'h22222, 2'b00, 2'b00},
        '{1'b0, 1'b1, 6'd0, 6'd2, 18'h0AAAA, 18'h15555, 2'b00, 2'b00},
        '{1'b0, 1'b1, 6'd0, 6'd3, 18'h3FFFF, 18'h00000, 2'b00, 2'b00},
        '{1'b1, 1'b0, 6'd1, 6'd0, 18'h00000, 18'h00000, 2'b11, 2'b11},
        '{1'b1, 1'b1, 6'd2, 6'd4, 18'h12345, 18'h0ABCD, 2'b00, 2'b00},
        '{1'b1, 1'b0, 6'd3, 6'd0, 18'h00000, 18'h00000, 2'b11, 2'b11},
        '{1'b1, 1'b0, 6'd4, 6'd0, 18'h00000, 18'h00000, 2'b11, 2'b11},
        '{1'b1, 1'b1, 6'd1, 6'd1, 18'h00155, 18'h3FE00, 2'b10, 2'b01},
        '{1'b0, 1'b0, 6'd0, 6'd0, 18'h00000, 18'h00000, 2'b11, 2'b11},
        '{1'b1, 1'b0, 6'd1, 6'd0, 18'h00000, 18'h00000, 2'b11, 2'b11},
        '{1'b1, 1'b0, 6'd2, 6'd2, 18'h3FFFF, 18'h3FFFF, 2'b00, 2'b00},
        '{1'b1, 1'b0, 6'd2, 6'd0, 18'h00000, 18'h00000, 2'b11, 2'b11},
        '{1'b0, 1'b0, 6'd0, 6'd0, 18'h00000, 18'h00000, 2'b11, 2'b11},
        '{1'b0, 1'b0, 6'd0, 6'd0, 18'h00000, 18'h00000, 2'b11, 2'b11}
    };

    function automatic string tag_of(input int i, input logic rd);
        if (!rd)              return "R3";
        if (i == 3)           return "R2";
        if (i == 4)           return "R9";
        if (i == 7)           return "R7";
        if (i == 9)           return "R5";
        if (i >= 10)          return "R6";
        return "R4";
    endfunction

    function automatic logic [17:0] mrg(input logic [17:0] old, input logic [17:0] nw,
                                        input logic [1:0] en_n);
        logic [17:0] r;
        r = old;
        if (!en_n[0]) r[8:0]  = nw[8:0];
        if (!en_n[1]) r[17:9] = nw[17:9];
        return r;
    endfunction

    task automatic chk(input string tag, input logic v, input logic [17:0] w);
        logic [17:0] e;
        e = v ? w : 18'h0;
        checks++;
        if (rd_valid !== v || rd_data !== e) begin
            failures++;
            $display("FAIL %s: rd_valid=%0b rd_data=%h expected rd_valid=%0b rd_data=%h",
                     tag, rd_valid, rd_data, v, e);
        end
    endtask

    // One K cycle: drive K-edge inputs, then K#-edge inputs; check both output slots.
    task automatic kcycle(input logic rd, input logic wr, input logic [5:0] ra,
                          input logic [5:0] wa, input logic [17:0] w0, input logic [17:0] w1,
                          input logic [1:0] b0n, input logic [1:0] b1n, input string tag);
        addr = ra; rd_sel_n = ~rd; wr_sel_n = ~wr; wdata = w0; wr_lane_n = b0n;
        @(posedge clk); @(negedge clk);
        chk(p2_tag, p2_v, p2_w1);
        addr = wa; rd_sel_n = 1'b1; wr_sel_n = 1'b1; wdata = w1; wr_lane_n = b1n;
        @(posedge clk); @(negedge clk);
        chk(p1_tag, p1_v, p1_w0);
        if (wr) begin
            ref0[wa] = mrg(ref0[wa], w0, b0n);
            ref1[wa] = mrg(ref1[wa], w1, b1n);
        end
        p2_v = p1_v; p2_w0 = p1_w0; p2_w1 = p1_w1; p2_tag = p1_tag;
        p1_v = rd; p1_w0 = rd ? ref0[ra] : '0; p1_w1 = rd ? ref1[ra] : '0; p1_tag = tag;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rd_sel_n = 1'b1; wr_sel_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", 1'b0, 18'h0);
        p1_v = 1'b0; p2_v = 1'b0; p1_tag = "R1"; p2_tag = "R1";
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", 1'b0, 18'h0);   // R1 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            kcycle(TBL[i].rd, TBL[i].wr, TBL[i].ra, TBL[i].wa, TBL[i].w0, TBL[i].w1,
                   TBL[i].b0n, TBL[i].b1n, tag_of(i, TBL[i].rd));
        end

        // R8: continuous read stream
        for (int a = 1; a <= 4; a++) begin
            kcycle(1'b1, 1'b0, 6'(a), 6'd0, 18'h0, 18'h0, 2'b11, 2'b11, "R8");
        end
        // R5 / R7: same-cycle write with no lanes enabled leaves old data
        kcycle(1'b1, 1'b1, 6'd3, 6'd3, 18'h00000, 18'h3FFFF, 2'b11, 2'b11, "R5");
        // R7: full forward of a new write to a fresh address
        kcycle(1'b1, 1'b1, 6'd9, 6'd9, 18'h2A5A5, 18'h15A5A, 2'b00, 2'b00, "R7");
        kcycle(1'b0, 1'b0, 6'd0, 6'd0, 18'h0, 18'h0, 2'b11, 2'b11, "R3");
        kcycle(1'b0, 1'b0, 6'd0, 6'd0, 18'h0, 18'h0, 2'b11, 2'b11, "R3");

        // R1: reset while a burst is in flight clears it
        kcycle(1'b1, 1'b0, 6'd9, 6'd0, 18'h0, 18'h0, 2'b11, 2'b11, "R1");
        do_reset();
        kcycle(1'b0, 1'b0, 6'd0, 6'd0, 18'h0, 18'h0, 2'b11, 2'b11, "R1");
        kcycle(1'b1, 1'b0, 6'd9, 6'd0, 18'h0, 18'h0, 2'b11, 2'b11, "R2");
        kcycle(1'b0, 1'b0, 6'd0, 6'd0, 18'h0, 18'h0, 2'b11, 2'b11, "R3");
        kcycle(1'b0, 1'b0, 6'd0, 6'd0, 18'h0, 18'h0, 2'b11, 2'b11, "R3");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule